// File: doc/BRIEF.md
# Oversampled UART receive engine

This block recovers asynchronous serial characters from a single receive line. A baud-rate generator outside the block supplies a one-cycle sampling pulse at sixteen times the bit rate, and every bit time is measured by counting those pulses. The line passes through a two-flop synchronizer. A falling edge on the idle line starts a frame. The start bit is confirmed half a bit later, and each following bit is sampled at the centre of its period.

Character length (5 to 8 bits), parity enable, parity sense and the number of stop bits are static configuration inputs. The block latches them when it detects the start edge. A finished character is placed in a one-deep holding register with a valid flag and four condition flags: framing, parity, overrun and break. A read strobe from the consumer empties the holding register. A FIFO, the rate generator and any register interface are outside the block.

Top module: `uart_rx_engine`

## Requirements
- R1: A frame starts only on a high-to-low change of the synchronized line. The start bit is sampled again on the 8th sampling pulse after the edge, and if the line is high at that point the frame is dropped with no character delivered. A low pulse of a quarter bit therefore produces nothing.
- R2: Data bits arrive least significant first, and each is sampled on every 16th pulse after the start check. The number of data bits is 5 + cfg_len (cfg_len 0..3). Output bits above the character length read 0.
- R3: After reset, rx_valid and all flags are 0. The holding register loads on the last stop-bit sample, which is the (8 + 16*B)th pulse after the start edge, where B counts data, parity and stop bits. rx_valid is 1 from the next cycle.
- R4: With cfg_par_en=1, one parity bit follows the data. With cfg_par_odd=0, the data bits plus the parity bit must hold an even number of ones; with cfg_par_odd=1, an odd number. err_parity is 1 when that count is wrong. With cfg_par_en=0, err_parity stays 0.
- R5: cfg_two_stop selects two stop bits instead of one. err_frame is 1 when any stop bit is sampled low.
- R6: err_break is 1 when every sampled bit of the frame, from start through the last stop bit, is low. Such a character also carries err_frame=1 and data 0.
- R7: err_overrun is 1 when a character completes while rx_valid is 1 and rd_strobe is not asserted in that cycle. The new character replaces the held one.
- R8: rd_strobe clears rx_valid and all four flags while rx_data keeps its value. A completing character in the same cycle takes priority over the read.
- R9: Configuration changes made while a frame is in progress do not affect that frame.
- R10: After a frame, a line that stays low starts no new frame until it has returned high and fallen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sampling pulse, 16 per bit time |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_len | input | 2 | Data bits minus five |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| rd_strobe | input | 1 | Consumer read of the holding register |
| rx_data | output | 8 | Received character, zero-filled above its length |
| rx_valid | output | 1 | Holding register full |
| err_frame | output | 1 | Stop bit sampled low |
| err_parity | output | 1 | Parity mismatch |
| err_overrun | output | 1 | Unread character was replaced |
| err_break | output | 1 | Whole frame low |

## Verification
The bench aims at these corner cases:
- A quarter-bit low glitch, which a design without the start re-check would turn into a spurious character.
- Five-bit characters sent from an all-ones byte, which expose missing zero-fill in the upper bits.
- A break followed by a long low line. A design that triggers on level instead of edge would deliver a second, phantom character.
- Back-to-back characters with and without a read in the completion cycle. These separate a correct overrun rule from one that ignores a simultaneous read.
- A length change in mid-frame, which catches configuration that was not latched at the start edge.

// File: rtl/uart_rx_engine.sv
module uart_rx_engine #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic       rd_strobe,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       err_frame,
  output logic       err_parity,
  output logic       err_overrun,
  output logic       err_break
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP1, STOP2} st_t;

  st_t st;
  logic s1, s2, prv;
  logic [CW-1:0] cnt;
  logic [2:0] idx;
  logic [7:0] sh;
  logic par_acc, all_low, fe_acc;
  logic [1:0] len_q;
  logic pen_q, podd_q, two_q;

  wire samp = tick16 && (st != IDLE) &&
              (cnt == ((st == START) ? CW'(HALF - 1) : CW'(OSR - 1)));
  wire fin  = samp && ((st == STOP1 && !two_q) || st == STOP2);
  wire fe_fin = !s2 || (st == STOP2 && fe_acc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; prv <= 1'b1;
      st <= IDLE; cnt <= '0; idx <= '0; sh <= '0;
      par_acc <= 1'b0; all_low <= 1'b0; fe_acc <= 1'b0;
      len_q <= '0; pen_q <= 1'b0; podd_q <= 1'b0; two_q <= 1'b0;
    end else begin
      s1 <= rxd; s2 <= s1; prv <= s2;
      if (st == IDLE) begin
        if (prv && !s2) begin
          st <= START; cnt <= '0; idx <= '0; sh <= '0;
          par_acc <= 1'b0; all_low <= 1'b1; fe_acc <= 1'b0;
          len_q <= cfg_len; pen_q <= cfg_par_en;
          podd_q <= cfg_par_odd; two_q <= cfg_two_stop;
        end
      end else if (tick16) begin
        cnt <= samp ? '0 : cnt + 1'b1;
        if (samp) begin
          all_low <= all_low & ~s2;
          case (st)
            START: st <= s2 ? IDLE : DATA;
            DATA: begin
              sh[idx] <= s2;
              par_acc <= par_acc ^ s2;
              if (idx == {1'b0, len_q} + 3'd4) st <= pen_q ? PAR : STOP1;
              else idx <= idx + 3'd1;
            end
            PAR: begin
              par_acc <= par_acc ^ s2;
              st <= STOP1;
            end
            STOP1: begin
              fe_acc <= ~s2;
              st <= two_q ? STOP2 : IDLE;
            end
            default: st <= IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0; rx_valid <= 1'b0;
      err_frame <= 1'b0; err_parity <= 1'b0;
      err_overrun <= 1'b0; err_break <= 1'b0;
    end else if (fin) begin
      rx_data     <= sh;
      rx_valid    <= 1'b1;
      err_frame   <= fe_fin;
      err_parity  <= pen_q & (par_acc ^ podd_q);
      err_break   <= all_low & ~s2;
      err_overrun <= rx_valid & ~rd_strobe;
    end else if (rd_strobe) begin
      rx_valid <= 1'b0;
      err_frame <= 1'b0; err_parity <= 1'b0;
      err_overrun <= 1'b0; err_break <= 1'b0;
    end
  end

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> ((rx_data >> ({2'b00, len_q} + 4'd5)) == 8'd0)); // R2

  AST_PARITY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !pen_q) |=> !err_parity); // R4

  AST_BREAK_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
    err_break |-> (err_frame && rx_data == 8'd0)); // R6

  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(rx_valid)); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !fin) |=> (!rx_valid && !err_frame && !err_parity &&
                             !err_overrun && !err_break)); // R8

  AST_GLITCH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == START && samp && s2) |=> (st == IDLE && $stable(rx_valid))); // R1
endmodule

// File: tb/tb_uart_rx_engine.sv
module tb_uart_rx_engine;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1, rd_strobe = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic [7:0] rx_data;
  logic rx_valid, err_frame, err_parity, err_overrun, err_break;

  uart_rx_engine dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_valid(rx_valid), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun), .err_break(err_break)
  );

  typedef struct { int when; logic [7:0] d; logic fe; logic pe; logic brk; } ev_t;
  ev_t q[$];
  ev_t ev;
  int cyc = 0, checks = 0, failures = 0;
  logic e_valid = 0, e_fe = 0, e_pe = 0, e_ovr = 0, e_brk = 0;
  logic [7:0] e_data = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      e_valid = 0; e_data = 0; e_fe = 0; e_pe = 0; e_ovr = 0; e_brk = 0;
    end else if (q.size() > 0 && q[0].when == cyc) begin
      ev = q.pop_front();
      e_ovr = e_valid && !rd_strobe;
      e_valid = 1; e_data = ev.d; e_fe = ev.fe; e_pe = ev.pe; e_brk = ev.brk;
    end else if (rd_strobe) begin
      e_valid = 0; e_fe = 0; e_pe = 0; e_ovr = 0; e_brk = 0;
    end
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) tick16 = ((cyc + 1) % 4 == 0);

  always @(negedge clk) if (rst_n) begin
    chk("R3 valid", {7'd0, rx_valid}, {7'd0, e_valid});
    chk("R2 data", rx_data, e_data);
    chk("R5 frame", {7'd0, err_frame}, {7'd0, e_fe});
    chk("R4 parity", {7'd0, err_parity}, {7'd0, e_pe});
    chk("R7 overrun", {7'd0, err_overrun}, {7'd0, e_ovr});
    chk("R6 break", {7'd0, err_break}, {7'd0, e_brk});
  end

  task automatic send(input logic [7:0] d, input int n, input bit pen, input bit podd,
                      input bit two, input bit bad_par, input bit bad_stop, input bit brk,
                      input bit rd_done, input bit cfg_mid, input int hold_low);
    logic bits [16];
    logic [7:0] ed;
    logic p, fe, pe, eb;
    int nb, k0, kd, ns;
    ns = two ? 2 : 1;
    nb = 1 + n + (pen ? 1 : 0) + ns;
    bits[0] = 1'b0;
    ed = 8'd0;
    for (int i = 0; i < n; i++) begin
      bits[1 + i] = brk ? 1'b0 : d[i];
      ed[i] = bits[1 + i];
    end
    p = (^ed) ^ podd;
    if (brk) p = 1'b0; else if (bad_par) p = ~p;
    if (pen) bits[1 + n] = p;
    for (int i = 0; i < ns; i++) bits[nb - ns + i] = !(brk || (bad_stop && i == 0));
    pe = pen && (p != ((^ed) ^ podd));
    fe = 1'b0;
    for (int i = nb - ns; i < nb; i++) if (!bits[i]) fe = 1'b1;
    eb = 1'b1;
    for (int i = 0; i < nb; i++) if (bits[i]) eb = 1'b0;
    cfg_len = 2'(n - 5); cfg_par_en = pen; cfg_par_odd = podd; cfg_two_stop = two;
    do @(negedge clk); while ((cyc + 1) % 4 != 1);
    k0 = cyc + 1;
    kd = k0 + 31 + 64 * (nb - 1);
    q.push_back('{kd, ed, fe, pe, eb});
    for (int j = 0; j < nb * 64; j++) begin
      rxd = bits[j / 64];
      rd_strobe = rd_done && (cyc + 1 == kd);
      if (cfg_mid && j == 192) cfg_len = ~cfg_len;
      @(negedge clk);
    end
    rd_strobe = 1'b0;
    for (int j = 0; j < hold_low; j++) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic read_now;
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R3 reset valid", {7'd0, rx_valid}, 8'd0);
    chk("R3 reset flags", {4'd0, err_frame, err_parity, err_overrun, err_break}, 8'd0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    send(8'hA5, 8, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 eight bits", rx_data, 8'hA5);
    read_now();
    send(8'hFF, 5, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R2 zero fill", rx_data, 8'h1F);
    read_now();
    send(8'h3C, 7, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 odd ok", {7'd0, err_parity}, 8'd0);
    read_now();
    send(8'h81, 8, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R4 bad parity", {7'd0, err_parity}, 8'd1);
    read_now();
    send(8'h2A, 6, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R5 bad stop", {7'd0, err_frame}, 8'd1);
    read_now();
    send(8'h55, 8, 1, 0, 1, 0, 1, 0, 0, 0, 0);
    chk("R5 two stop first low", {7'd0, err_frame}, 8'd1);
    read_now();
    send(8'h00, 8, 1, 1, 0, 0, 0, 1, 0, 0, 300);
    chk("R6 break", {7'd0, err_break}, 8'd1);
    chk("R10 no restart", {7'd0, err_overrun}, 8'd0);
    read_now();
    repeat (100) @(negedge clk);
    chk("R10 idle after break", {7'd0, rx_valid}, 8'd0);

    send(8'h11, 8, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    send(8'h22, 8, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 overrun", {7'd0, err_overrun}, 8'd1);
    chk("R7 replaced", rx_data, 8'h22);
    read_now();
    chk("R8 data held", rx_data, 8'h22);
    send(8'h33, 8, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    send(8'h44, 8, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R8 read at completion", {7'd0, err_overrun}, 8'd0);
    chk("R8 valid kept", {7'd0, rx_valid}, 8'd1);
    read_now();

    do @(negedge clk); while ((cyc + 1) % 4 != 1);
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    chk("R1 glitch rejected", {7'd0, rx_valid}, 8'd0);

    send(8'hC3, 8, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R9 config latched", rx_data, 8'hC3);
    read_now();
    repeat (20) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule